// File: doc/BRIEF.md
# SCSI Byte Packing Register Unit

This block sits between the 8-bit data path of a SCSI bus controller and a 32-bit memory port. In the receive direction it gathers incoming bytes into four byte lanes, which together form two 16-bit pack registers (high and low). Each time the lanes fill, it issues one 32-bit memory write in big-endian order. In the send direction it takes 32-bit words from memory and hands them back out as bytes, most significant byte first.

A transfer begins with a FIFO reset. On that cycle the unit samples the two low bits of the transfer start address. An odd address is an error and freezes both directions. An address with bit 1 set selects halfword-alignment mode: the first two bytes of a receive travel as a single 16-bit write, and the first word of a send contributes only its low halfword. After that, packing proceeds on full 32-bit words.

A flush ends a receive. Bytes that arrived but never formed a full write stay in the pack registers at fixed positions, and a left-over count reports how many there are, so the host can copy them out. Memory arbitration is handled outside the block.

Top module: `scsi_byte_packer`

## Requirements
- R1: After `rst_n` low or a cycle with `fifo_rst` high, `pk_hi`, `pk_lo` and `lob` are zero. `half_mode` takes `start_align[1]` and `addr_err` takes `start_align[0]` as sampled on the `fifo_rst` cycle; after `rst_n` both are zero.
- R2: While `addr_err` is 1, `in_ready` and `wd_ready` stay 0. Bytes offered on the input change neither `lob` nor the pack registers, and no write is issued.
- R3: With `half_mode` 0, the fourth accepted byte produces one write on the next cycle: `wr_valid`=1, `wr_half`=0, `wr_data` = {byte1, byte2, byte3, byte4}, where byte1 is the earliest.
- R4: With `half_mode` 0 and k of 1 to 3 bytes held, the bytes sit in `pk_hi[15:8]`, `pk_hi[7:0]` and `pk_lo[15:8]` in arrival order, unused positions read zero, and `lob` = k.
- R5: With `half_mode` 1, the second accepted byte produces on the next cycle `wr_valid`=1, `wr_half`=1, `wr_data[15:0]` = {first, second}, and `wr_data[31:16]` = 0. `half_mode` then drops to 0, and packing continues as in R3.
- R6: With `half_mode` 1 and one byte held, that byte sits in `pk_lo[15:8]`, `lob` = 1, and `pk_hi` is zero.
- R7: In receive direction (`dir_send`=0), after a cycle with `flush` high, `in_ready` stays 0 until the next `fifo_rst`. `lob`, `pk_hi` and `pk_lo` keep their values.
- R8: In send direction, a word is taken (`wd_valid` and `wd_ready`) only while no byte is held. Its bytes appear on `out_data` most significant first, each held until `out_valid` and `out_ready` are both 1. `wd_ready` is 0 while `out_valid` is 1.
- R9: In send direction with `half_mode` 1, the first word taken yields only two bytes: `wd_data[15:8]`, then `wd_data[7:0]`. Later words yield four bytes each.
- R10: When `flush` falls in the same cycle as the byte that completes a write, that write is still issued as in R3 or R5. Afterwards `lob` is 0, and `in_ready` stays 0 as in R7.
- R11: After a write is issued, the pack registers read zero until the next byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_rst | input | 1 | Start of transfer: clears the lanes and samples `start_align` |
| start_align | input | 2 | Low two bits of the transfer start address |
| dir_send | input | 1 | 1 = memory to SCSI, 0 = SCSI to memory |
| flush | input | 1 | End of receive: stop taking bytes |
| in_valid | input | 1 | Receive byte offered |
| in_data | input | 8 | Receive byte |
| in_ready | output | 1 | Receive byte taken this cycle when valid |
| wd_valid | input | 1 | Send word offered |
| wd_data | input | 32 | Send word |
| wd_ready | output | 1 | Send word taken this cycle when valid |
| out_valid | output | 1 | Send byte available |
| out_data | output | 8 | Send byte |
| out_ready | input | 1 | Send byte consumed |
| wr_valid | output | 1 | Memory write strobe, one cycle |
| wr_half | output | 1 | Write is 16-bit, data in `wr_data[15:0]` |
| wr_data | output | 32 | Memory write data, big-endian |
| pk_hi | output | 16 | High pack register |
| pk_lo | output | 16 | Low pack register |
| lob | output | 2 | Left-over byte count in receive direction |
| half_mode | output | 1 | Halfword-alignment mode active |
| addr_err | output | 1 | Odd start address seen |

## Verification
Two things can happen in the same cycle: a flush, and the byte that completes a word or halfword. The bench sets up this collision on purpose in both alignment modes by raising `flush` together with the final byte. It then checks three things: the write still reaches the monitor with the expected data, `lob` reads zero, and `in_ready` stays low afterwards. A second overlap comes from a FIFO reset that arrives while bytes are held. That case is judged by checking that the pack registers and the left-over count are cleared on the following cycle, and that the new alignment is picked up.

// File: rtl/scsi_byte_packer_pkg.sv
`timescale 1ns/1ps
package scsi_byte_packer_pkg;
   typedef enum logic [2:0] {
      LOP_IDLE   = 3'd0,
      LOP_CLEAR  = 3'd1,
      LOP_PUT    = 3'd2,
      LOP_LAST   = 3'd3,
      LOP_LOAD_W = 3'd4,
      LOP_LOAD_H = 3'd5,
      LOP_SHIFT  = 3'd6
   } lane_op_e;
endpackage

// File: rtl/scsi_byte_packer_ctrl.sv
`timescale 1ns/1ps
module scsi_byte_packer_ctrl
   import scsi_byte_packer_pkg::*;
#(
   parameter int LANES = 4,
   localparam int IDX_W  = $clog2(LANES),
   localparam int CNT_W  = $clog2(LANES + 1),
   localparam int HALF_L = LANES / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_rst,
   input  logic [1:0]       start_align,
   input  logic             dir_send,
   input  logic             flush,
   input  logic             in_valid,
   input  logic             wd_valid,
   input  logic             out_ready,
   output logic             in_ready,
   output logic             wd_ready,
   output logic             out_valid,
   output lane_op_e         op,
   output logic [IDX_W-1:0] put_idx,
   output logic             wr_go,
   output logic             wr_half_go,
   output logic [IDX_W-1:0] lob,
   output logic             half_mode,
   output logic             addr_err
);
   logic [CNT_W-1:0] cnt_q;
   logic             hm_q, err_q, hold_q;
   logic             rx_acc, tx_acc, tx_pop, rx_last;

   assign in_ready  = !dir_send && !err_q && !hold_q && !fifo_rst;
   assign wd_ready  = dir_send && !err_q && (cnt_q == '0) && !fifo_rst;
   assign out_valid = dir_send && (cnt_q != '0);

   assign rx_acc = in_valid && in_ready;
   assign tx_acc = wd_valid && wd_ready;
   assign tx_pop = out_valid && out_ready;

   assign rx_last = hm_q ? (cnt_q == CNT_W'(HALF_L - 1))
                         : (cnt_q == CNT_W'(LANES - 1));
   assign put_idx = IDX_W'(hm_q ? cnt_q + CNT_W'(HALF_L) : cnt_q);

   always_comb begin
      if (fifo_rst)    op = LOP_CLEAR;
      else if (rx_acc) op = rx_last ? LOP_LAST : LOP_PUT;
      else if (tx_acc) op = hm_q ? LOP_LOAD_H : LOP_LOAD_W;
      else if (tx_pop) op = LOP_SHIFT;
      else             op = LOP_IDLE;
   end

   assign wr_go      = (op == LOP_LAST);
   assign wr_half_go = hm_q;
   assign lob        = dir_send ? '0 : cnt_q[IDX_W-1:0];
   assign half_mode  = hm_q;
   assign addr_err   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hm_q   <= 1'b0;
         err_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         case (op)
            LOP_CLEAR: begin
               cnt_q <= '0;
               hm_q  <= start_align[1];
               err_q <= start_align[0];
            end
            LOP_PUT:    cnt_q <= cnt_q + 1'b1;
            LOP_LAST: begin
               cnt_q <= '0;
               hm_q  <= 1'b0;
            end
            LOP_LOAD_W: cnt_q <= CNT_W'(LANES);
            LOP_LOAD_H: begin
               cnt_q <= CNT_W'(HALF_L);
               hm_q  <= 1'b0;
            end
            LOP_SHIFT:  cnt_q <= cnt_q - 1'b1;
            default:    ;
         endcase
         if (fifo_rst)
            hold_q <= 1'b0;
         else if (flush && !dir_send)
            hold_q <= 1'b1;
      end
   end
endmodule

// File: rtl/scsi_byte_packer_lanes.sv
`timescale 1ns/1ps
module scsi_byte_packer_lanes
   import scsi_byte_packer_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W  = $clog2(LANES),
   localparam int WORD_W = BYTE_W * LANES,
   localparam int HALF_W = WORD_W / 2,
   localparam int HALF_L = LANES / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_op_e          op,
   input  logic [IDX_W-1:0]  put_idx,
   input  logic [BYTE_W-1:0] in_data,
   input  logic [WORD_W-1:0] wd_data,
   input  logic              wr_go,
   input  logic              wr_half_go,
   output logic [WORD_W-1:0] pk_word,
   output logic              wr_valid,
   output logic              wr_half,
   output logic [WORD_W-1:0] wr_data
);
   logic [LANES:0][BYTE_W-1:0] lane_w;
   logic [WORD_W-1:0]          word_c, wr_word;

   assign lane_w[LANES] = '0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [BYTE_W-1:0] q;
      logic [BYTE_W-1:0] half_src;
      if (i < HALF_L) begin : g_hsrc
         assign half_src = wd_data[HALF_W-1-i*BYTE_W -: BYTE_W];
      end else begin : g_hzero
         assign half_src = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else begin
            case (op)
               LOP_CLEAR, LOP_LAST: q <= '0;
               LOP_PUT:    if (put_idx == IDX_W'(i)) q <= in_data;
               LOP_LOAD_W: q <= wd_data[WORD_W-1-i*BYTE_W -: BYTE_W];
               LOP_LOAD_H: q <= half_src;
               LOP_SHIFT:  q <= lane_w[i+1];
               default:    ;
            endcase
         end
      end
      assign lane_w[i] = q;
      assign pk_word[WORD_W-1-i*BYTE_W -: BYTE_W] = q;
   end

   always_comb begin
      for (int j = 0; j < LANES; j++)
         word_c[WORD_W-1-j*BYTE_W -: BYTE_W] = (j == LANES-1) ? in_data : lane_w[j];
      wr_word = wr_half_go ? {{HALF_W{1'b0}}, word_c[HALF_W-1:0]} : word_c;
   end

   if (OUT_REG) begin : g_wr_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_half  <= 1'b0;
            wr_data  <= '0;
         end else begin
            wr_valid <= wr_go;
            wr_half  <= wr_go && wr_half_go;
            if (wr_go) wr_data <= wr_word;
         end
      end
   end else begin : g_wr_comb
      assign wr_valid = wr_go;
      assign wr_half  = wr_go && wr_half_go;
      assign wr_data  = wr_word;
   end
endmodule

// File: rtl/scsi_byte_packer.sv
`timescale 1ns/1ps
module scsi_byte_packer
   import scsi_byte_packer_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W  = $clog2(LANES),
   localparam int WORD_W = BYTE_W * LANES,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_rst,
   input  logic [1:0]        start_align,
   input  logic              dir_send,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   input  logic              wd_valid,
   input  logic [WORD_W-1:0] wd_data,
   output logic              wd_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic              out_ready,
   output logic              wr_valid,
   output logic              wr_half,
   output logic [WORD_W-1:0] wr_data,
   output logic [HALF_W-1:0] pk_hi,
   output logic [HALF_W-1:0] pk_lo,
   output logic [IDX_W-1:0]  lob,
   output logic              half_mode,
   output logic              addr_err
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be positive");
   end

   lane_op_e          op;
   logic [IDX_W-1:0]  put_idx;
   logic              wr_go, wr_half_go;
   logic [WORD_W-1:0] pk_word;

   scsi_byte_packer_ctrl #(.LANES(LANES)) u_ctrl (
      .clk, .rst_n, .fifo_rst, .start_align, .dir_send, .flush,
      .in_valid, .wd_valid, .out_ready,
      .in_ready, .wd_ready, .out_valid,
      .op, .put_idx, .wr_go, .wr_half_go,
      .lob, .half_mode, .addr_err
   );

   scsi_byte_packer_lanes #(.BYTE_W(BYTE_W), .LANES(LANES), .OUT_REG(OUT_REG)) u_lanes (
      .clk, .rst_n, .op, .put_idx, .in_data, .wd_data,
      .wr_go, .wr_half_go, .pk_word,
      .wr_valid, .wr_half, .wr_data
   );

   assign pk_hi    = pk_word[WORD_W-1:HALF_W];
   assign pk_lo    = pk_word[HALF_W-1:0];
   assign out_data = pk_word[WORD_W-1 -: BYTE_W];
endmodule

// File: rtl/scsi_byte_packer_chk.sv
`timescale 1ns/1ps
module scsi_byte_packer_chk #(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W  = $clog2(LANES),
   localparam int WORD_W = BYTE_W * LANES,
   localparam int HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_rst,
   input logic              dir_send,
   input logic              flush,
   input logic              in_valid,
   input logic              in_ready,
   input logic              wd_ready,
   input logic              out_valid,
   input logic              wr_valid,
   input logic              wr_half,
   input logic [WORD_W-1:0] wr_data,
   input logic [HALF_W-1:0] pk_hi,
   input logic [HALF_W-1:0] pk_lo,
   input logic [IDX_W-1:0]  lob,
   input logic              half_mode,
   input logic              addr_err
);
   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> (lob == '0) && (pk_hi == '0) && (pk_lo == '0));

   assert_err_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> !in_ready && !wd_ready);

   if (OUT_REG) begin : g_r3
      assert_word_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && !half_mode && lob == IDX_W'(LANES-1) && !fifo_rst)
         |=> wr_valid && !wr_half);
   end

   assert_half_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_half) |-> (wr_data[WORD_W-1:HALF_W] == '0));

   assert_half_hi_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (half_mode && !dir_send) |-> (pk_hi == '0));

   assert_flush_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !fifo_rst && !dir_send) |=> !in_ready);

   assert_no_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !wd_ready);
endmodule

bind scsi_byte_packer scsi_byte_packer_chk #(.BYTE_W(BYTE_W), .LANES(LANES), .OUT_REG(OUT_REG)) u_chk (
   .clk, .rst_n, .fifo_rst, .dir_send, .flush, .in_valid, .in_ready, .wd_ready,
   .out_valid, .wr_valid, .wr_half, .wr_data, .pk_hi, .pk_lo, .lob,
   .half_mode, .addr_err
);

// File: tb/scsi_byte_packer_test.sv
`timescale 1ns/1ps
module scsi_byte_packer_test;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        fifo_rst = 0, dir_send = 0, flush = 0;
   logic [1:0]  start_align = 0;
   logic        in_valid = 0, wd_valid = 0, out_ready = 0;
   logic [7:0]  in_data = 0;
   logic [31:0] wd_data = 0;
   logic        in_ready, wd_ready, out_valid, wr_valid, wr_half, half_mode, addr_err;
   logic [7:0]  out_data;
   logic [31:0] wr_data;
   logic [15:0] pk_hi, pk_lo;
   logic [1:0]  lob;

   int nchk = 0, nfail = 0;
   bit done = 0;
   int          m_cnt;
   bit          m_hm, m_err;
   logic [7:0]  m_lane [4];
   logic [32:0] exp_q [$];

   scsi_byte_packer uut (.*);

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   // write monitor: compares every memory write with the model queue (R3, R5)
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (exp_q.size() == 0) chk(0, "R3 unexpected write", {31'b0, wr_half, wr_data}, 0);
         else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk({wr_half, wr_data} == e, e[32] ? "R5 half write" : "R3 word write",
                {31'b0, wr_half, wr_data}, {31'b0, e});
         end
      end
   end

   task automatic model_clear();
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_lane[i] = 8'h00;
   endtask

   task automatic unit_reset(input logic [1:0] al, input bit snd);
      fifo_rst = 1; start_align = al; dir_send = snd;
      step();
      fifo_rst = 0;
      model_clear();
      m_hm = al[1]; m_err = al[0];
      chk(lob == 0 && pk_hi == 0 && pk_lo == 0, "R1 clear", {pk_hi, pk_lo, 14'b0, lob}, 0);
      chk(half_mode == m_hm && addr_err == m_err, "R1 align sample",
          {half_mode, addr_err}, {m_hm, m_err});
   endtask

   task automatic check_held(input string req);
      chk(lob == 2'(m_cnt), req, lob, m_cnt);
      chk(pk_hi == {m_lane[0], m_lane[1]} && pk_lo == {m_lane[2], m_lane[3]}, req,
          {pk_hi, pk_lo}, {m_lane[0], m_lane[1], m_lane[2], m_lane[3]});
      chk(half_mode == m_hm, req, half_mode, m_hm);
   endtask

   task automatic rx_byte(input logic [7:0] b, input bit fl);
      in_valid = 1; in_data = b; flush = fl;
      #1 chk(in_ready == 1'b1, "R7 ready before byte", in_ready, 1);
      step();
      in_valid = 0; flush = 0;
      if (m_hm) begin
         m_lane[2 + m_cnt] = b;
         if (m_cnt == 1) begin
            exp_q.push_back({1'b1, 16'h0, m_lane[2], b});
            model_clear(); m_hm = 0;
         end else m_cnt++;
      end else begin
         m_lane[m_cnt] = b;
         if (m_cnt == 3) begin
            exp_q.push_back({1'b0, m_lane[0], m_lane[1], m_lane[2], b});
            model_clear();
         end else m_cnt++;
      end
   endtask

   task automatic tx_word(input logic [31:0] w);
      logic [7:0] eb [$];
      wd_valid = 1; wd_data = w;
      #1 chk(wd_ready == 1'b1, "R8 ready when empty", wd_ready, 1);
      step();
      wd_valid = 0;
      if (m_hm) begin
         eb = '{w[15:8], w[7:0]}; m_hm = 0;   // R9
      end else eb = '{w[31:24], w[23:16], w[15:8], w[7:0]};
      while (eb.size() > 0) begin
         out_ready = ($urandom % 3) != 0;
         #1;
         chk(out_valid && !wd_ready, "R8 busy", {out_valid, wd_ready}, 2'b10);
         if (out_ready) begin
            logic [7:0] e;
            e = eb.pop_front();
            chk(out_data == e, "R8 R9 byte order", out_data, e);
         end
         step();
      end
      out_ready = 0;
      #1 chk(!out_valid && wd_ready, "R8 drained", {out_valid, wd_ready}, 2'b01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      model_clear(); m_hm = 0; m_err = 0;
      repeat (3) step();
      rst_n = 1;
      step();
      check_held("R1 after rst_n");
      chk(in_ready && !wr_valid && !addr_err, "R1 rst state", {in_ready, wr_valid, addr_err}, 3'b100);

      // full word, fill order and lane clear after write
      unit_reset(2'b00, 0);
      rx_byte(8'h11, 0); check_held("R4 one");
      rx_byte(8'h22, 0); check_held("R4 two");
      rx_byte(8'h33, 0); check_held("R4 three");
      rx_byte(8'h44, 0); check_held("R11 cleared after write");
      step(); chk(exp_q.size() == 0, "R3 write seen", exp_q.size(), 0);

      // three left over, flush, ignored input, then clear
      rx_byte(8'hA1, 0); rx_byte(8'hA2, 0); rx_byte(8'hA3, 0);
      flush = 1; step(); flush = 0;
      #1 chk(in_ready == 0, "R7 stopped", in_ready, 0);
      in_valid = 1; in_data = 8'hFF; step(); step(); in_valid = 0;
      check_held("R7 held bytes kept");
      unit_reset(2'b00, 0);

      // halfword alignment mode
      unit_reset(2'b10, 0);
      rx_byte(8'h55, 0); check_held("R6 single in low");
      rx_byte(8'h66, 0); check_held("R5 mode dropped");
      rx_byte(8'h01, 0); rx_byte(8'h02, 0); rx_byte(8'h03, 0); rx_byte(8'h04, 0);
      step(); chk(exp_q.size() == 0, "R5 writes seen", exp_q.size(), 0);

      // odd address
      unit_reset(2'b01, 0);
      in_valid = 1; in_data = 8'h77;
      #1 chk(in_ready == 0, "R2 rx blocked", in_ready, 0);
      step(); step(); in_valid = 0;
      check_held("R2 nothing taken");
      unit_reset(2'b11, 1);
      wd_valid = 1; #1 chk(wd_ready == 0 && out_valid == 0, "R2 tx blocked", {wd_ready, out_valid}, 0);
      step(); wd_valid = 0;

      // flush with completing byte, both modes
      unit_reset(2'b00, 0);
      rx_byte(8'hC1, 0); rx_byte(8'hC2, 0); rx_byte(8'hC3, 0); rx_byte(8'hC4, 1);
      #1 chk(in_ready == 0 && lob == 0, "R10 flush with last", {in_ready, lob}, 0);
      step(); chk(exp_q.size() == 0, "R10 write seen", exp_q.size(), 0);
      unit_reset(2'b10, 0);
      rx_byte(8'hD1, 0); rx_byte(8'hD2, 1);
      #1 chk(in_ready == 0 && lob == 0, "R10 flush with half", {in_ready, lob}, 0);
      step(); chk(exp_q.size() == 0, "R10 half seen", exp_q.size(), 0);

      // FIFO reset while bytes held
      unit_reset(2'b00, 0);
      rx_byte(8'hE1, 0); rx_byte(8'hE2, 0);
      unit_reset(2'b10, 0);
      check_held("R1 reset over held");

      // send direction
      unit_reset(2'b00, 1);
      tx_word(32'h8899AABB);
      tx_word(32'h01234567);
      unit_reset(2'b10, 1);
      tx_word(32'hDEADBEEF);
      tx_word(32'hCAFEF00D);

      // constrained random rounds
      for (int r = 0; r < 40; r++) begin
         bit snd;
         snd = $urandom % 2;
         unit_reset(($urandom % 2) ? 2'b10 : 2'b00, snd);
         if (!snd) begin
            int n;
            n = $urandom % 12;
            for (int k = 0; k < n; k++) begin
               repeat ($urandom % 3) step();
               rx_byte(8'($urandom), 0);
            end
            check_held(m_hm ? "R6 random held" : "R4 random held");
            step();
            chk(exp_q.size() == 0, "R3 random writes", exp_q.size(), 0);
         end else begin
            int n;
            n = 1 + $urandom % 3;
            for (int k = 0; k < n; k++) tx_word($urandom);
         end
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule